// File: doc/BRIEF.md
# Oversampled Receiver Phase and Byte Aligner

This block sits behind a bank of serial-line samplers that capture the line three times per bit period. Each core clock it receives a word of twelve samples that covers four bit periods. It registers the word once more to let late-settling samplers resolve. It then searches the sample stream for the rising edge of a start bit on a line that idles low. From the sample position of that edge it picks which of the three sample phases lands nearest the bit centres. It also works out which decimated bit is the first data bit. Both choices are kept in registers.

Once the choices are made, every word is reduced from twelve samples to four bits by taking one sample per bit. A shifter uses the stored bit offset to form 4-bit groups that begin on the first data bit, and pairs of groups are packed into bytes. Each byte is announced with a one-clock valid pulse. A `rearm` pulse between packets drops the lock and starts a new search. Synchronous reset does the same, and also clears the stored choices.

Top module: `ovs_phase_byte_align`

## Requirements
- R1: Within `samp_in`, bit 0 is the oldest sample and bit 11 the newest, and samples 3k..3k+2 span data bit k. A word takes part in decisions one clock after it is captured: when the start edge lies in the word captured at edge n, `locked` reads 1 after edge n+1.
- R2: The start edge is the oldest sample that reads 1 while the sample before it reads 0. For sample 0 the sample before it is sample 11 of the previous word. With no such sample, `locked` stays 0.
- R3: With q the index within its word of the first 1 sample of the start edge, `phase_sel` becomes (q+1) mod 3.
- R4: `bit_off` becomes ((q+4) mod 12) div 3, the index of the first data bit within its word. When q is 8 or more, the first data bit lies in the following word.
- R5: After lock, decimated data bit k of a word is sample 3k+`phase_sel`, so every data bit is sampled at the sample that follows the start edge by a whole number of bit periods.
- R6: Bytes are LSB first. Bit i of byte j is data bit 8j+i counted from the first data bit after the start bit, and the first 4-bit group of a pair forms the low nibble.
- R7: If the first data bit lies in the word captured at edge f, byte j appears with `byte_vld` high after edge f+2j+3 for exactly one clock. `byte_vld` is never high on two consecutive clocks and is never high while `locked` is 0.
- R8: While `locked` is 1, further rising edges in the data change neither `phase_sel` nor `bit_off`, and `locked` stays 1 until `rearm` or reset.
- R9: One clock after `rearm` is high, `locked` and `byte_vld` are 0 and any half-assembled byte is discarded. The next packet is found afresh, and its bytes contain no stale bits.
- R10: One clock after `rst` is high, `locked`, `byte_vld`, `phase_sel` and `bit_off` are all 0, and the sample history reads as idle-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm | input | 1 | Drop lock and search for a new start bit |
| samp_in | input | 12 | Twelve oversampled line samples, bit 0 oldest |
| locked | output | 1 | Start bit found; phase and offset frozen |
| phase_sel | output | 2 | Chosen sample phase, 0 to 2 |
| bit_off | output | 2 | Position of the first data bit within a decimated word |
| byte_out | output | 8 | Aligned data byte, LSB first |
| byte_vld | output | 1 | One-clock strobe marking a new byte |

## Verification
Clean packets are sent with the start edge at every one of the twelve positions in a word and at several word distances from the rearm. These packets separate the three phase choices, the four offsets and the case where data starts in the following word. The position where the edge straddles the word boundary checks that the previous word's last sample is used. Random sample streams, whose data is full of further rising edges, show that only the first edge counts and that the frozen choices hold. A quiet line, a packet cut off after half a byte, and a reset in mid-stream show that nothing locks without an edge and that no stale state survives into the next packet.

// File: rtl/ovs_align_pkg.sv
package ovs_align_pkg;

    localparam int OVS_SAMPLES_PER_BIT = 3;
    localparam int OVS_BITS_PER_WORD   = 4;
    localparam int OVS_BYTE_BITS       = 8;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SKIP   = 2'd1,
        ST_STREAM = 2'd2
    } align_state_e;

    // sample index of the start-bit centre, for an edge at sample pos
    function automatic int centre_of(int pos, int spb);
        return pos + spb / 2;
    endfunction

    function automatic int phase_of(int pos, int spb);
        return centre_of(pos, spb) % spb;
    endfunction

    // centre of the first data bit, measured in the detection word
    function automatic int first_data_of(int pos, int spb);
        return centre_of(pos, spb) + spb;
    endfunction

    function automatic int offset_of(int pos, int spb, int bpw);
        return (first_data_of(pos, spb) % (spb * bpw)) / spb;
    endfunction

    function automatic bit skip_of(int pos, int spb, int bpw);
        return first_data_of(pos, spb) >= (spb * bpw);
    endfunction

endpackage

// File: rtl/ovs_sample_sync.sv
module ovs_sample_sync #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    // one resolving stage, then one word of history for the edge scan
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            prev <= '0;
        end else begin
            cur  <= din;
            prev <= cur;
        end
    end

endmodule

// File: rtl/ovs_start_finder.sv
module ovs_start_finder #(
    parameter int SAMPLES_PER_BIT = 3,
    parameter int BITS_PER_WORD   = 4,
    parameter int PH_W            = 2,
    parameter int OFF_W           = 2
) (
    input  logic [SAMPLES_PER_BIT*BITS_PER_WORD-1:0] cur,
    input  logic                                     prev_last,
    output logic                                     found,
    output logic [PH_W-1:0]                          phase,
    output logic [OFF_W-1:0]                         offset,
    output logic                                     skip
);
    import ovs_align_pkg::*;

    localparam int W = SAMPLES_PER_BIT * BITS_PER_WORD;

    logic [W:0] ext;
    assign ext = {cur, prev_last};

    // descending scan so that the oldest edge is the one left standing
    always_comb begin
        found  = 1'b0;
        phase  = '0;
        offset = '0;
        skip   = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (!ext[i] && ext[i+1]) begin
                found  = 1'b1;
                phase  = PH_W'(phase_of(i, SAMPLES_PER_BIT));
                offset = OFF_W'(offset_of(i, SAMPLES_PER_BIT, BITS_PER_WORD));
                skip   = skip_of(i, SAMPLES_PER_BIT, BITS_PER_WORD);
            end
        end
    end

endmodule

// File: rtl/ovs_decimator.sv
module ovs_decimator #(
    parameter int SAMPLES_PER_BIT = 3,
    parameter int BITS_PER_WORD   = 4,
    parameter int PH_W            = 2
) (
    input  logic [SAMPLES_PER_BIT*BITS_PER_WORD-1:0] samples,
    input  logic [PH_W-1:0]                          phase,
    output logic [BITS_PER_WORD-1:0]                 bits
);

    for (genvar k = 0; k < BITS_PER_WORD; k++) begin : g_pick
        logic [SAMPLES_PER_BIT-1:0] triplet;
        assign triplet = samples[k*SAMPLES_PER_BIT +: SAMPLES_PER_BIT];
        assign bits[k] = triplet[phase];
    end

endmodule

// File: rtl/ovs_byte_packer.sv
module ovs_byte_packer #(
    parameter int BITS_PER_WORD = 4,
    parameter int BYTE_BITS     = 8,
    parameter int OFF_W         = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     accept,
    input  logic [BITS_PER_WORD-1:0] dec_cur,
    input  logic [BITS_PER_WORD-1:0] dec_prev,
    input  logic [OFF_W-1:0]         offset,
    output logic [BYTE_BITS-1:0]     byte_out,
    output logic                     byte_vld
);

    localparam int GROUPS = BYTE_BITS / BITS_PER_WORD;
    localparam int CNT_W  = (GROUPS > 2) ? $clog2(GROUPS) : 1;
    localparam int SEL_W  = $clog2(2 * BITS_PER_WORD);
    localparam int ACC_W  = (GROUPS - 1) * BITS_PER_WORD;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GROUPS - 1);

    logic [2*BITS_PER_WORD-1:0] window;
    logic [SEL_W-1:0]           sel;
    logic [BITS_PER_WORD-1:0]   grp;
    logic [ACC_W-1:0]           acc;
    logic [CNT_W-1:0]           cnt;

    // older word in the low half, so the offset counts from the older word
    assign window = {dec_cur, dec_prev};
    assign sel    = SEL_W'(offset);
    assign grp    = window[sel +: BITS_PER_WORD];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc      <= '0;
            cnt      <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (accept) begin
                if (cnt == LAST) begin
                    byte_out <= {grp, acc};
                    byte_vld <= 1'b1;
                    cnt      <= '0;
                end else begin
                    acc[int'(cnt)*BITS_PER_WORD +: BITS_PER_WORD] <= grp;
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/ovs_phase_byte_align.sv
module ovs_phase_byte_align #(
    parameter int SAMPLES_PER_BIT = ovs_align_pkg::OVS_SAMPLES_PER_BIT,
    parameter int BITS_PER_WORD   = ovs_align_pkg::OVS_BITS_PER_WORD,
    parameter int BYTE_BITS       = ovs_align_pkg::OVS_BYTE_BITS,
    localparam int W              = SAMPLES_PER_BIT * BITS_PER_WORD,
    localparam int PH_W           = $clog2(SAMPLES_PER_BIT),
    localparam int OFF_W          = $clog2(BITS_PER_WORD)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rearm,
    input  logic [W-1:0]         samp_in,
    output logic                 locked,
    output logic [PH_W-1:0]      phase_sel,
    output logic [OFF_W-1:0]     bit_off,
    output logic [BYTE_BITS-1:0] byte_out,
    output logic                 byte_vld
);
    import ovs_align_pkg::*;

    logic [W-1:0]             s_cur;
    logic [W-1:0]             s_prev;
    logic                     hit_found;
    logic [PH_W-1:0]          hit_phase;
    logic [OFF_W-1:0]         hit_off;
    logic                     hit_skip;
    logic [BITS_PER_WORD-1:0] dec_cur;
    logic [BITS_PER_WORD-1:0] dec_prev;
    align_state_e             state_q;
    logic [PH_W-1:0]          phase_mem;
    logic [OFF_W-1:0]         word_mem;

    ovs_sample_sync #(.WIDTH(W)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (samp_in),
        .cur  (s_cur),
        .prev (s_prev)
    );

    ovs_start_finder #(
        .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
        .BITS_PER_WORD   (BITS_PER_WORD),
        .PH_W            (PH_W),
        .OFF_W           (OFF_W)
    ) finder_i (
        .cur       (s_cur),
        .prev_last (s_prev[W-1]),
        .found     (hit_found),
        .phase     (hit_phase),
        .offset    (hit_off),
        .skip      (hit_skip)
    );

    // phase and word memories, written only while searching
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_SEARCH;
            phase_mem <= '0;
            word_mem  <= '0;
        end else if (rearm) begin
            state_q <= ST_SEARCH;
        end else begin
            case (state_q)
                ST_SEARCH: begin
                    if (hit_found) begin
                        phase_mem <= hit_phase;
                        word_mem  <= hit_off;
                        state_q   <= hit_skip ? ST_SKIP : ST_STREAM;
                    end
                end
                ST_SKIP:   state_q <= ST_STREAM;
                default:   state_q <= ST_STREAM;
            endcase
        end
    end

    ovs_decimator #(
        .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
        .BITS_PER_WORD   (BITS_PER_WORD),
        .PH_W            (PH_W)
    ) dec_cur_i (
        .samples (s_cur),
        .phase   (phase_mem),
        .bits    (dec_cur)
    );

    ovs_decimator #(
        .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
        .BITS_PER_WORD   (BITS_PER_WORD),
        .PH_W            (PH_W)
    ) dec_prev_i (
        .samples (s_prev),
        .phase   (phase_mem),
        .bits    (dec_prev)
    );

    ovs_byte_packer #(
        .BITS_PER_WORD (BITS_PER_WORD),
        .BYTE_BITS     (BYTE_BITS),
        .OFF_W         (OFF_W)
    ) packer_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (rearm),
        .accept   (state_q == ST_STREAM),
        .dec_cur  (dec_cur),
        .dec_prev (dec_prev),
        .offset   (word_mem),
        .byte_out (byte_out),
        .byte_vld (byte_vld)
    );

    assign locked    = (state_q != ST_SEARCH);
    assign phase_sel = phase_mem;
    assign bit_off   = word_mem;

endmodule

// File: rtl/ovs_phase_byte_align_chk.sv
module ovs_phase_byte_align_chk #(
    parameter int SAMPLES_PER_BIT = 3,
    parameter int BITS_PER_WORD   = 4,
    localparam int PH_W           = $clog2(SAMPLES_PER_BIT),
    localparam int OFF_W          = $clog2(BITS_PER_WORD)
) (
    input logic             clk,
    input logic             rst,
    input logic             rearm,
    input logic             locked,
    input logic [PH_W-1:0]  phase_sel,
    input logic [OFF_W-1:0] bit_off,
    input logic             byte_vld
);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!locked && !byte_vld && phase_sel == '0 && bit_off == '0));

    // R7
    vld_single_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    // R7
    vld_locked_chk: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> locked);

    // R8
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked && !rearm) |=> (locked && $stable(phase_sel) && $stable(bit_off)));

    // R9
    rearm_drop_chk: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (!locked && !byte_vld));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(phase_sel) < SAMPLES_PER_BIT);

endmodule

bind ovs_phase_byte_align ovs_phase_byte_align_chk #(
    .SAMPLES_PER_BIT (SAMPLES_PER_BIT),
    .BITS_PER_WORD   (BITS_PER_WORD)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rearm     (rearm),
    .locked    (locked),
    .phase_sel (phase_sel),
    .bit_off   (bit_off),
    .byte_vld  (byte_vld)
);

// File: tb/ovs_phase_byte_align_tb.sv
module ovs_phase_byte_align_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WS         = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rearm = 1'b0;
    logic [11:0] samp_in = '0;
    logic        locked;
    logic [1:0]  phase_sel;
    logic [1:0]  bit_off;
    logic [7:0]  byte_out;
    logic        byte_vld;

    int n_chk  = 0;
    int n_fail = 0;

    bit seg[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ovs_phase_byte_align dut_i (
        .clk       (clk),
        .rst       (rst),
        .rearm     (rearm),
        .samp_in   (samp_in),
        .locked    (locked),
        .phase_sel (phase_sel),
        .bit_off   (bit_off),
        .byte_out  (byte_out),
        .byte_vld  (byte_vld)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R6: bit i of byte j is the centre sample of data bit 8j+i
    function automatic logic [7:0] exp_byte(input int a, input int j);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            int idx = a + 4 + 3 * (8 * j + i);
            b[i] = (idx < seg.size()) ? seg[idx] : 1'b0;
        end
        return b;
    endfunction

    task automatic check_reset_state(input string tag);
        chk(locked == 1'b0, "R10", {tag, " locked"}, locked, 0);
        chk(byte_vld == 1'b0, "R10", {tag, " byte_vld"}, byte_vld, 0);
        chk(phase_sel == 2'd0, "R10", {tag, " phase_sel"}, phase_sel, 0);
        chk(bit_off == 2'd0, "R10", {tag, " bit_off"}, bit_off, 0);
    endtask

    // rearm, then play seg word by word, comparing with the model each clock
    task automatic play_segment(input int rst_at);
        int a = -1;
        int nw = seg.size() / WS;
        int fw;
        for (int i = 0; i < seg.size(); i++) begin
            bit prior = (i == 0) ? 1'b0 : seg[i-1];
            if (!prior && seg[i]) begin
                a = i;
                break;
            end
        end
        fw = (a + 4) / WS;

        @(negedge clk);
        rearm   = 1'b1;
        samp_in = '0;
        @(posedge clk); #1;
        // R9: lock and strobe dropped by the rearm
        chk(locked == 1'b0, "R9", "locked after rearm", locked, 0);
        chk(byte_vld == 1'b0, "R9", "byte_vld after rearm", byte_vld, 0);

        for (int i = 0; i < nw; i++) begin
            logic [11:0] w;
            bit exp_lock;
            bit exp_vld;
            for (int b = 0; b < WS; b++) w[b] = seg[WS*i + b];
            @(negedge clk);
            rearm   = 1'b0;
            samp_in = w;
            rst     = (i == rst_at);
            @(posedge clk); #1;
            if (i == rst_at) begin
                check_reset_state("mid-stream reset");
                @(negedge clk);
                rst = 1'b0;
                return;
            end
            exp_lock = (a >= 0) && (i >= a / WS + 1);
            if (a < 0)
                chk(locked == exp_lock, "R2", "locked, no start edge", locked, exp_lock);
            else if (i <= a / WS + 1)
                chk(locked == exp_lock, "R1", "locked timing", locked, exp_lock);
            else
                chk(locked == exp_lock, "R8", "locked held", locked, exp_lock);
            if (exp_lock) begin
                chk(int'(phase_sel) == (a + 1) % 3, "R3", "phase_sel",
                    phase_sel, (a + 1) % 3);
                chk(int'(bit_off) == ((a + 4) % WS) / 3, "R4", "bit_off",
                    bit_off, ((a + 4) % WS) / 3);
            end
            exp_vld = (a >= 0) && (i - fw - 3 >= 0) && ((i - fw - 3) % 2 == 0);
            chk(byte_vld == exp_vld, "R7", "byte_vld", byte_vld, exp_vld);
            if (exp_vld && byte_vld) begin
                logic [7:0] eb = exp_byte(a, (i - fw - 3) / 2);
                // R5 decimation phase and R6 packing order seen together
                chk(byte_out == eb, "R6", "byte_out", byte_out, eb);
            end
        end
    endtask

    task automatic build_packet(input int a, input int nbytes, input int nw);
        seg.delete();
        for (int i = 0; i < nw * WS; i++) seg.push_back(1'b0);
        for (int k = 0; k < 3; k++) seg[a + k] = 1'b1;
        for (int m = 0; m < 8 * nbytes; m++) begin
            bit d = 1'($urandom_range(0, 1));
            for (int k = 0; k < 3; k++)
                if (a + 3 + 3 * m + k < nw * WS) seg[a + 3 + 3 * m + k] = d;
        end
    endtask

    task automatic build_random(input int lead, input int nw);
        seg.delete();
        for (int i = 0; i < nw * WS; i++)
            seg.push_back((i < lead) ? 1'b0 : 1'($urandom_range(0, 1)));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("power-on reset");
        @(negedge clk);
        rst = 1'b0;

        // every start position in a word, at three word distances (R2, R3, R4, R5)
        for (int q = 0; q < WS; q++) begin
            int a = WS * (q % 3) + q;
            int fw = (a + 4) / WS;
            build_packet(a, 3, fw + 2 * 3 + 4);
            play_segment(-1);
        end

        // random streams: first edge wins, later edges ignored (R2, R8)
        for (int r = 0; r < 8; r++) begin
            build_random(int'($urandom_range(0, 30)), 14);
            play_segment(-1);
        end

        // quiet line never locks (R2)
        seg.delete();
        for (int i = 0; i < 6 * WS; i++) seg.push_back(1'b0);
        play_segment(-1);

        // packet cut after half a byte, next packet clean (R9)
        build_packet(5, 2, 3);
        play_segment(-1);
        build_packet(14, 2, 10);
        play_segment(-1);

        // reset in mid-stream, then a clean packet (R10)
        build_packet(7, 3, 12);
        play_segment(6);
        build_packet(20, 2, 10);
        play_segment(-1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule